// File: doc/BRIEF.md
# Integer/Float Conversion Unit

This unit converts a 32-bit two's-complement integer into an IEEE-754 single-precision value, or a single-precision value into a 32-bit two's-complement integer. A function code picks the direction. A 2-bit rounding control decides what happens to bits that do not fit in the destination format. A request is a one-cycle `valid_i` strobe that carries the function code, the rounding mode and the operand.

The unit takes several cycles per request. A single 64-bit shift register serves both directions. For integer-to-float it shifts left one bit per cycle until the magnitude is normalised. For float-to-integer it shifts the mantissa left by a count taken from the exponent. One rounding stage then produces the result.

When the result is ready, it is presented on `result_o` together with an inexact flag, and `done_o` pulses for one cycle. While a conversion is in progress, further requests are dropped.

Top module: `int_float_cvt`

## Requirements
- R1: With function code 0x04 the operand is read as a signed integer. The result is its single-precision value, rounded to a 24-bit significand, with the sign bit (bit 31) equal to the operand's sign, the biased exponent in bits 30:23 and the fraction in bits 22:0.
- R2: With function code 0x05 the operand is read as a single-precision value, with the fields laid out as in R1. The result is the rounded value as a signed 32-bit integer. A zero exponent field marks a subnormal, which has no hidden one.
- R3: The rounding control selects how to round: 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward positive infinity and 3 rounds toward negative infinity.
- R4: Integer 0 converts to 0x00000000 (+0.0). Integer 0x80000000 converts exactly to 0xCF000000: sign 1, exponent 158, fraction 0.
- R5: In float-to-integer, the following cases give a fixed result and leave the inexact flag low:
  - a NaN (exponent 255, non-zero fraction) gives 0x7FFFFFFF;
  - any non-NaN value of 2^31 or more gives 0x7FFFFFFF;
  - any value of -2^31 or less gives 0x80000000.
- R6: `inexact_o` is high with a result if and only if the bits that rounding discarded were not all zero.
- R7: After reset `result_o`, `inexact_o` and `done_o` are 0. `done_o` is high for exactly one cycle per conversion, and `result_o` changes only in a cycle where `done_o` is high.
- R8: A request that arrives while a conversion is in progress is ignored. It does not change the result in progress and does not produce a `done_o` of its own.
- R9: A request whose function code is neither 0x04 nor 0x05 is ignored. No `done_o` follows it and `result_o` keeps its value.
- R10: `done_o` rises no more than 42 cycles after the clock edge that accepted the request.
- R11: In float-to-integer, zeros of either sign give 0. Nonzero magnitudes below one half, including subnormals, give 0 except in two cases, which give 1 or -1: positive values rounded toward positive infinity, and negative values rounded toward negative infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; taken only when idle |
| func_i | input | FUNC_W (8) | Function code: 0x04 int-to-float, 0x05 float-to-int |
| rmode_i | input | 2 | Rounding mode (see R3) |
| operand_i | input | 32 | Integer or single-precision operand |
| result_o | output | 32 | Converted value, held until the next completion |
| done_o | output | 1 | One-cycle completion pulse |
| inexact_o | output | 1 | Discarded bits were non-zero |

## Verification
Every exponent from below the one-half point up past the saturation edge is swept, with both signs, several fraction patterns and all four rounding modes. This exercises both the shift count taken from the exponent and the sticky collapse for tiny values. A unit that counted one shift too many or too few would scale every result by two, and one that lost the sticky bit would round tiny values wrongly in the directed modes.

Integer inputs are swept over every leading-one position, with exact powers, all-ones tails and just-above-power patterns. These cover exact results, the significand carry that bumps the exponent, and ties. A wrong tie rule shows up on 2^24+1 and 2^24+3 and on 2.5 and 3.5.

The most negative integer, NaN, the infinities and 2^31 check the saturation paths. A request arriving mid-conversion and unknown function codes check that nothing leaks into the result or produces a stray completion.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int INT_W    = 32;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int MANT_W   = FRAC_W + 1;
  localparam int ACC_W    = 2 * INT_W;
  localparam int CNT_W    = 6;
  localparam int BIAS     = 127;
  // exponent of a value whose leading one sits at integer bit INT_W-1
  localparam int EXP_TOP  = BIAS + INT_W - 1;
  // exponent at which the mantissa needs no shift to reach the binary point
  localparam int EXP_LOAD = BIAS + FRAC_W - INT_W;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_FIN
  } state_e;
endpackage

// File: rtl/cvt_unpack.sv
module cvt_unpack
  import cvt_pkg::*;
(
  input  logic             to_float_i,
  input  logic [INT_W-1:0] op_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sign_o,
  output logic             special_o,
  output logic             tiny_o,
  output logic [INT_W-1:0] special_val_o
);
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [MANT_W-1:0] mant_f;
  logic [INT_W-1:0]  mag;

  always_comb begin
    exp_f         = op_i[INT_W-2 -: EXP_W];
    frac_f        = op_i[FRAC_W-1:0];
    mant_f        = {|exp_f, frac_f};
    mag           = op_i[INT_W-1] ? (~op_i + 1'b1) : op_i;
    sign_o        = op_i[INT_W-1];
    acc_o         = '0;
    cnt_o         = '0;
    special_o     = 1'b0;
    tiny_o        = 1'b0;
    special_val_o = '0;
    if (to_float_i) begin
      acc_o     = {mag, {INT_W{1'b0}}};
      special_o = (op_i == '0);
    end else if ((&exp_f) && (|frac_f)) begin
      special_o     = 1'b1;
      special_val_o = POS_SAT;
    end else if (exp_f >= EXP_W'(EXP_TOP)) begin
      special_o     = 1'b1;
      special_val_o = op_i[INT_W-1] ? NEG_SAT : POS_SAT;
    end else if (exp_f < EXP_W'(EXP_LOAD)) begin
      // magnitude below one half: only the sticky survives
      tiny_o = |mant_f;
    end else begin
      acc_o = {{(ACC_W-MANT_W){1'b0}}, mant_f};
      cnt_o = CNT_W'(exp_f - EXP_W'(EXP_LOAD));
    end
  end
endmodule

// File: rtl/cvt_shifter.sv
module cvt_shifter
  import cvt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  input  logic             count_up_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      cnt_o <= '0;
    end else if (load_i) begin
      acc_o <= acc_i;
      cnt_o <= cnt_i;
    end else if (step_i) begin
      acc_o <= {acc_o[ACC_W-2:0], 1'b0};
      cnt_o <= count_up_i ? cnt_o + 1'b1 : cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import cvt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] keep_i,
  input  logic         round_bit_i,
  input  logic         sticky_i,
  input  logic         neg_i,
  input  rmode_e       rmode_i,
  output logic [W:0]   sum_o,
  output logic         inexact_o
);
  logic inc;
  logic lost;

  always_comb begin
    lost = round_bit_i | sticky_i;
    unique case (rmode_i)
      RM_NEAREST: inc = round_bit_i & (sticky_i | keep_i[0]);
      RM_ZERO:    inc = 1'b0;
      RM_UP:      inc = lost & ~neg_i;
      default:    inc = lost & neg_i;
    endcase
    sum_o     = {1'b0, keep_i} + {{W{1'b0}}, inc};
    inexact_o = lost;
  end
endmodule

// File: rtl/int_float_cvt.sv
module int_float_cvt
  import cvt_pkg::*;
#(
  parameter int                FUNC_W      = 8,
  parameter logic [FUNC_W-1:0] FN_TO_FLOAT = FUNC_W'(8'h04),
  parameter logic [FUNC_W-1:0] FN_TO_INT   = FUNC_W'(8'h05)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [1:0]        rmode_i,
  input  logic [INT_W-1:0]  operand_i,
  output logic [INT_W-1:0]  result_o,
  output logic              done_o,
  output logic              inexact_o
);
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  state_e           state_q;
  logic             to_float_q, sign_q, special_q, tiny_q;
  rmode_e           rm_q;
  logic [INT_W-1:0] spec_val_q;

  logic             accept, step;
  logic [ACC_W-1:0] un_acc, acc;
  logic [CNT_W-1:0] un_cnt, cnt;
  logic             un_sign, un_special, un_tiny;
  logic [INT_W-1:0] un_spec_val;

  logic [INT_W-1:0] keep;
  logic             rbit, sticky;
  logic [INT_W:0]   sum;
  logic             rnd_inexact;
  logic [EXP_W-1:0] f_exp;
  logic [INT_W-1:0] float_res, int_res, final_res;
  logic             final_inexact;

  assign accept = (state_q == ST_IDLE) && valid_i &&
                  ((func_i == FN_TO_FLOAT) || (func_i == FN_TO_INT));

  cvt_unpack u_unpack (
    .to_float_i    (func_i == FN_TO_FLOAT),
    .op_i          (operand_i),
    .acc_o         (un_acc),
    .cnt_o         (un_cnt),
    .sign_o        (un_sign),
    .special_o     (un_special),
    .tiny_o        (un_tiny),
    .special_val_o (un_spec_val)
  );

  // to-float: normalise until the top bit is set, counting shifts up
  // to-int: shift by the exponent-derived count, counting down
  assign step = (state_q == ST_SHIFT) && !special_q &&
                (to_float_q ? !acc[ACC_W-1] : (cnt != '0));

  cvt_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .acc_i      (un_acc),
    .cnt_i      (un_cnt),
    .step_i     (step),
    .count_up_i (to_float_q),
    .acc_o      (acc),
    .cnt_o      (cnt)
  );

  always_comb begin
    if (to_float_q) begin
      keep   = {{(INT_W-MANT_W){1'b0}}, acc[ACC_W-1 -: MANT_W]};
      rbit   = acc[ACC_W-MANT_W-1];
      sticky = |acc[ACC_W-MANT_W-2:0];
    end else begin
      keep   = acc[ACC_W-1 -: INT_W];
      rbit   = acc[INT_W-1];
      sticky = (|acc[INT_W-2:0]) | tiny_q;
    end
  end

  cvt_round #(.W(INT_W)) u_round (
    .keep_i      (keep),
    .round_bit_i (rbit),
    .sticky_i    (sticky),
    .neg_i       (sign_q),
    .rmode_i     (rm_q),
    .sum_o       (sum),
    .inexact_o   (rnd_inexact)
  );

  always_comb begin
    // significand carry out bumps the exponent; fraction is then zero
    f_exp     = EXP_W'(EXP_TOP) - EXP_W'(cnt) + {{(EXP_W-1){1'b0}}, sum[MANT_W]};
    float_res = {sign_q, f_exp, sum[FRAC_W-1:0]};
    if (!sign_q && (sum > {1'b0, POS_SAT}))
      int_res = POS_SAT;
    else if (sign_q && (sum > {1'b0, NEG_SAT}))
      int_res = NEG_SAT;
    else
      int_res = sign_q ? (~sum[INT_W-1:0] + 1'b1) : sum[INT_W-1:0];
    if (special_q) begin
      final_res     = spec_val_q;
      final_inexact = 1'b0;
    end else begin
      final_res     = to_float_q ? float_res : int_res;
      final_inexact = rnd_inexact;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      to_float_q <= 1'b0;
      sign_q     <= 1'b0;
      special_q  <= 1'b0;
      tiny_q     <= 1'b0;
      rm_q       <= RM_NEAREST;
      spec_val_q <= '0;
      result_o   <= '0;
      inexact_o  <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            to_float_q <= (func_i == FN_TO_FLOAT);
            sign_q     <= un_sign;
            special_q  <= un_special;
            tiny_q     <= un_tiny;
            rm_q       <= rmode_e'(rmode_i);
            spec_val_q <= un_spec_val;
            state_q    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (!step) state_q <= ST_FIN;
        end
        ST_FIN: begin
          result_o  <= final_res;
          inexact_o <= final_inexact;
          done_o    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cvt_checker.sv
module cvt_checker #(
  parameter int                FUNC_W      = 8,
  parameter logic [FUNC_W-1:0] FN_TO_FLOAT = FUNC_W'(8'h04),
  parameter logic [FUNC_W-1:0] FN_TO_INT   = FUNC_W'(8'h05),
  parameter int                LAT_MAX     = 42
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [FUNC_W-1:0] func_i,
  input logic [31:0]       operand_i,
  input logic [31:0]       result_o,
  input logic              done_o,
  input logic              inexact_o
);
  logic              pend_q;
  logic [7:0]        lat_q;
  logic [FUNC_W-1:0] fn_q;
  logic [31:0]       op_q;
  logic              take;

  assign take = valid_i && ((func_i == FN_TO_FLOAT) || (func_i == FN_TO_INT)) &&
                (!pend_q || done_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lat_q  <= '0;
      fn_q   <= '0;
      op_q   <= '0;
    end else if (take) begin
      pend_q <= 1'b1;
      lat_q  <= '0;
      fn_q   <= func_i;
      op_q   <= operand_i;
    end else if (done_o) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o); // R7
  AST_DONE_HAS_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pend_q); // R8
  AST_LATENCY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (lat_q <= 8'(LAT_MAX))); // R10
  AST_NAN_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fn_q == FN_TO_INT && (&op_q[30:23]) && (|op_q[22:0]))
      |-> (result_o == 32'h7FFF_FFFF && !inexact_o)); // R5
  AST_ZERO_TO_PLUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fn_q == FN_TO_FLOAT && op_q == 32'h0)
      |-> (result_o == 32'h0 && !inexact_o)); // R4
  AST_SIGN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fn_q == FN_TO_FLOAT && op_q != 32'h0)
      |-> (result_o[31] == op_q[31])); // R1
endmodule

bind int_float_cvt cvt_checker #(
  .FUNC_W      (FUNC_W),
  .FN_TO_FLOAT (FN_TO_FLOAT),
  .FN_TO_INT   (FN_TO_INT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .func_i    (func_i),
  .operand_i (operand_i),
  .result_o  (result_o),
  .done_o    (done_o),
  .inexact_o (inexact_o)
);

// File: tb/sim_int_float_cvt.sv
module sim_int_float_cvt;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [7:0]  func_i;
  logic [1:0]  rmode_i;
  logic [31:0] operand_i;
  logic [31:0] result_o;
  logic        done_o;
  logic        inexact_o;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  int_float_cvt u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .func_i    (func_i),
    .rmode_i   (rmode_i),
    .operand_i (operand_i),
    .result_o  (result_o),
    .done_o    (done_o),
    .inexact_o (inexact_o)
  );

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // cmp: -1 below half, 0 exactly half, 1 above half
  function automatic logic round_up(input logic [1:0] rm, input logic neg,
                                    input logic lsb, input int cmp, input logic nz);
    case (rm)
      2'd0:    return (cmp > 0) || (cmp == 0 && lsb);
      2'd1:    return 1'b0;
      2'd2:    return nz && !neg;
      default: return nz && neg;
    endcase
  endfunction

  function automatic int cmp_half(input logic [63:0] rem, input logic [63:0] half);
    if (rem > half) return 1;
    if (rem == half) return 0;
    return -1;
  endfunction

  task automatic ref_itof(input logic [1:0] rm, input logic [31:0] x,
                          output logic [31:0] r, output logic inx);
    logic        neg;
    logic [63:0] mag, keep, rem, half;
    int          p, d, e;
    if (x == 32'h0) begin
      r = 32'h0; inx = 1'b0; return;
    end
    neg = x[31];
    mag = {32'h0, (neg ? (32'h0 - x) : x)};
    p = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) p = i;
    e = 127 + p;
    if (p <= 23) begin
      keep = mag << (23 - p);
      inx  = 1'b0;
    end else begin
      d    = p - 23;
      keep = mag >> d;
      rem  = mag & ((64'h1 << d) - 1);
      half = 64'h1 << (d - 1);
      inx  = (rem != 0);
      keep = keep + {63'h0, round_up(rm, neg, keep[0], cmp_half(rem, half), inx)};
      if (keep == (64'h1 << 24)) begin
        keep = keep >> 1;
        e    = e + 1;
      end
    end
    r = {neg, e[7:0], keep[22:0]};
  endtask

  task automatic ref_ftoi(input logic [1:0] rm, input logic [31:0] f,
                          output logic [31:0] r, output logic inx);
    logic        neg;
    int          e, d, cmp;
    logic [63:0] m, ival, rem;
    neg = f[31];
    e   = int'(f[30:23]);
    inx = 1'b0;
    if (e == 255 && f[22:0] != 0) begin
      r = 32'h7FFF_FFFF; return;
    end
    if (e >= 158) begin
      r = neg ? 32'h8000_0000 : 32'h7FFF_FFFF; return;
    end
    m = {40'h0, (e != 0), f[22:0]};
    cmp = -1;
    if (e >= 150) begin
      ival = m << (e - 150);
    end else begin
      d = 150 - e;
      if (d >= 25) begin
        ival = 64'h0;
        inx  = (m != 0);
      end else begin
        ival = m >> d;
        rem  = m & ((64'h1 << d) - 1);
        inx  = (rem != 0);
        cmp  = cmp_half(rem, 64'h1 << (d - 1));
      end
    end
    ival = ival + {63'h0, round_up(rm, neg, ival[0], cmp, inx)};
    r = neg ? (32'h0 - ival[31:0]) : ival[31:0];
  endtask

  task automatic issue(input logic [7:0] fn, input logic [1:0] rm, input logic [31:0] op,
                       output logic [31:0] r, output logic inx, output logic got);
    @(negedge clk);
    valid_i = 1'b1; func_i = fn; rmode_i = rm; operand_i = op;
    @(negedge clk);
    valid_i = 1'b0;
    got = 1'b0;
    for (int n = 0; n < 60; n++) begin
      if (done_o) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
    r = result_o; inx = inexact_o;
  endtask

  task automatic check(input string req, input logic got, input logic [31:0] r, input logic inx,
                       input logic [31:0] er, input logic einx, input logic [31:0] op);
    vectors++;
    if (!got || r !== er || inx !== einx) begin
      errors++;
      $display("FAIL %s: op %h done %b result %h inexact %b, expected %h inexact %b",
               req, op, got, r, inx, er, einx);
    end
  endtask

  task automatic run_itof(input string req, input logic [1:0] rm, input logic [31:0] op);
    logic [31:0] r, er; logic inx, einx, got;
    ref_itof(rm, op, er, einx);
    issue(8'h04, rm, op, r, inx, got);
    check(req, got, r, inx, er, einx, op);
  endtask

  task automatic run_ftoi(input string req, input logic [1:0] rm, input logic [31:0] op);
    logic [31:0] r, er; logic inx, einx, got;
    ref_ftoi(rm, op, er, einx);
    issue(8'h05, rm, op, r, inx, got);
    check(req, got, r, inx, er, einx, op);
  endtask

  task automatic direct(input string req, input logic [7:0] fn, input logic [1:0] rm,
                        input logic [31:0] op, input logic [31:0] er, input logic einx);
    logic [31:0] r; logic inx, got;
    issue(fn, rm, op, r, inx, got);
    check(req, got, r, inx, er, einx, op);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, hold;
    logic inx, got;
    int extra;
    rst_ni = 1'b0; valid_i = 1'b0; func_i = '0; rmode_i = '0; operand_i = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset", 1'b1, result_o, inexact_o | done_o, 32'h0, 1'b0, 32'h0);
    rst_ni = 1'b1;

    // R4 special integers
    direct("R4 zero", 8'h04, 2'd0, 32'h0000_0000, 32'h0000_0000, 1'b0);
    direct("R4 most negative", 8'h04, 2'd2, 32'h8000_0000, 32'hCF00_0000, 1'b0);
    // R1 R3 R6 ties to even on 2^24+1 and 2^24+3
    direct("R1 R3 tie down", 8'h04, 2'd0, 32'h0100_0001, 32'h4B80_0000, 1'b1);
    direct("R1 R3 tie up", 8'h04, 2'd0, 32'h0100_0003, 32'h4B80_0002, 1'b1);
    direct("R3 rtz max int", 8'h04, 2'd1, 32'h7FFF_FFFF, 32'h4EFF_FFFF, 1'b1);
    direct("R3 up max int", 8'h04, 2'd2, 32'h7FFF_FFFF, 32'h4F00_0000, 1'b1);
    // R2 R3 float ties and directed modes
    direct("R2 R3 2.5 even", 8'h05, 2'd0, 32'h4020_0000, 32'h0000_0002, 1'b1);
    direct("R2 R3 3.5 even", 8'h05, 2'd0, 32'h4060_0000, 32'h0000_0004, 1'b1);
    direct("R3 -2.5 down", 8'h05, 2'd3, 32'hC020_0000, 32'hFFFF_FFFD, 1'b1);
    direct("R3 -2.5 zero", 8'h05, 2'd1, 32'hC020_0000, 32'hFFFF_FFFE, 1'b1);
    // R11 zeros and tiny values
    direct("R11 neg zero", 8'h05, 2'd3, 32'h8000_0000, 32'h0000_0000, 1'b0);
    direct("R11 0.5 up", 8'h05, 2'd2, 32'h3F00_0000, 32'h0000_0001, 1'b1);
    direct("R11 subnormal down", 8'h05, 2'd3, 32'h8000_0001, 32'hFFFF_FFFF, 1'b1);
    direct("R11 subnormal near", 8'h05, 2'd0, 32'h0000_0001, 32'h0000_0000, 1'b1);
    // R5 saturation
    direct("R5 nan", 8'h05, 2'd0, 32'h7FC0_0000, 32'h7FFF_FFFF, 1'b0);
    direct("R5 neg nan", 8'h05, 2'd3, 32'hFF80_0001, 32'h7FFF_FFFF, 1'b0);
    direct("R5 +inf", 8'h05, 2'd0, 32'h7F80_0000, 32'h7FFF_FFFF, 1'b0);
    direct("R5 -inf", 8'h05, 2'd0, 32'hFF80_0000, 32'h8000_0000, 1'b0);
    direct("R5 2^31", 8'h05, 2'd2, 32'h4F00_0000, 32'h7FFF_FFFF, 1'b0);
    direct("R5 -2^31", 8'h05, 2'd0, 32'hCF00_0000, 32'h8000_0000, 1'b0);

    // R1 R3 R6 sweep of leading-one position, sign and mode
    for (int p = 0; p < 32; p++)
      for (int k = 0; k < 3; k++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 4; m++) begin
            logic [31:0] pat;
            pat = (k == 0) ? (32'h1 << p) :
                  (k == 1) ? ((32'h1 << p) | 32'h1) : ((32'h1 << p) | ((32'h1 << p) - 1));
            run_itof("R1 R3 R6 sweep", 2'(m), (s == 1) ? (32'h0 - pat) : pat);
          end

    // R2 R3 R6 R11 sweep over exponents around the integer range
    for (int e = 100; e <= 170; e++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++)
          for (int m = 0; m < 4; m++) begin
            logic [22:0] fr;
            fr = (k == 0) ? 23'h0 : (k == 1) ? 23'h1 : (k == 2) ? 23'h40_0000 : 23'h7F_FFFF;
            run_ftoi("R2 R3 R6 R11 sweep", 2'(m), {s[0], e[7:0], fr});
          end

    // R1 R2 R6 random operands
    for (int i = 0; i < 300; i++) begin
      rng = next_rng(rng);
      run_itof("R1 R6 random", rng[1:0], rng);
      rng = next_rng(rng);
      run_ftoi("R2 R6 random", rng[1:0], {rng[31], 2'b10, rng[28:0]});
    end

    // R8: request during a busy conversion is dropped
    @(negedge clk);
    valid_i = 1'b1; func_i = 8'h05; rmode_i = 2'd0; operand_i = 32'h4EFF_FFFF;
    @(negedge clk);
    operand_i = 32'h3F80_0000;
    repeat (10) @(negedge clk);
    valid_i = 1'b0;
    got = 1'b0;
    for (int n = 0; n < 60; n++) begin
      if (done_o) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check("R8 busy keeps first", got, result_o, inexact_o, 32'h7FFF_FF80, 1'b0, 32'h4EFF_FFFF);
    @(negedge clk);
    // R7: completion pulse is one cycle wide
    check("R7 pulse width", 1'b1, {31'h0, done_o}, 1'b0, 32'h0, 1'b0, 32'h0);
    extra = 0;
    for (int n = 0; n < 60; n++) begin
      if (done_o) extra++;
      @(negedge clk);
    end
    check("R8 no second done", 1'b1, extra, 1'b0, 32'h0, 1'b0, 32'h3F80_0000);
    check("R8 result held", 1'b1, result_o, 1'b0, 32'h7FFF_FF80, 1'b0, 32'h3F80_0000);

    // R9: unknown function codes
    hold = result_o;
    for (int c = 0; c < 3; c++) begin
      logic [7:0] fn;
      fn = (c == 0) ? 8'h00 : (c == 1) ? 8'h14 : 8'h06;
      @(negedge clk);
      valid_i = 1'b1; func_i = fn; operand_i = 32'h4000_0000;
      @(negedge clk);
      valid_i = 1'b0;
      extra = 0;
      for (int n = 0; n < 50; n++) begin
        if (done_o) extra++;
        @(negedge clk);
      end
      check("R9 no done", 1'b1, extra, 1'b0, 32'h0, 1'b0, {24'h0, fn});
      check("R9 result kept", 1'b1, result_o, 1'b0, hold, 1'b0, {24'h0, fn});
    end

    // R10: longest shift path completes in time
    @(negedge clk);
    valid_i = 1'b1; func_i = 8'h05; rmode_i = 2'd1; operand_i = 32'hCEFF_FFFF;
    @(negedge clk);
    valid_i = 1'b0;
    got = 1'b0;
    for (int n = 0; n < 42; n++) begin
      if (done_o) begin got = 1'b1; break; end
      @(negedge clk);
    end
    r = result_o; inx = inexact_o;
    check("R10 latency", got, r, inx, 32'h8000_0080, 1'b0, 32'hCEFF_FFFF);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule